// File: doc/BRIEF.md
# Strided Aperture Address Translator

This block sits on the address side of an 8-bit host with a 16-bit address bus and decides, for each host access, whether the access belongs to a page-granular window that is backed by a large external memory. When it does, the block produces a wide physical address. The mapping is two-dimensional. The offset into the window is split by a programmable line width into a column and a row. Each row advances the physical address by a stride counted in 256-byte pages. A long virtual line in external memory therefore appears to the host as a flat, linear stretch of its own address space. The host scrolls the view sideways by one byte by changing the base by one. It scrolls the view down by one line by changing the base by stride×256.

One descriptor configures the window: a physical base, a host start page, a window size in pages, a stride in pages per line and a line width in bytes. The host writes it one byte at a time through an 8-bit register port into a shadow copy. A commit strobe moves the shadow copy into the active copy in one step, so translation never uses a half-written descriptor. Translation requests use a valid/ready handshake. The divide and modulo are done by a bit-serial divider, so every response arrives a fixed 16 cycles after it is accepted. This holds for hits, misses and the linear case alike. The response is held until the consumer takes it.

The controller has three states. In SX_IDLE, req_ready is high. A request moves it to SX_DIVIDE, which runs one divider step per cycle. It leaves SX_DIVIDE for SX_DONE after the last step. SX_DONE presents rsp_valid and returns to SX_IDLE when rsp_ready is high.

Top module: `stride_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and the active descriptor is all zero, so every address misses.
- R2: A write with cfg_we high stores cfg_wdata into the shadow byte chosen by cfg_sel. The codes are:
  - 0 to 3: base bytes, least significant first.
  - 4: start page.
  - 5: size in pages.
  - 6: stride.
  - 7 and 8: width, low byte at 7.
  - Other codes are ignored.
  Shadow writes do not affect translation until a cycle with cfg_commit high copies all shadow bytes into the active descriptor.
- R3: An address hits when its upper byte (page) satisfies start ≤ page < start + size. The sum is computed without wrap in 9 bits, so a size of 0 never hits.
- R4: On a hit with width ≠ 0, let offset = address − start×256, column = offset mod width and row = offset div width. Then rsp_phys = base + row×stride×256 + column, modulo 2^32.
- R5: On a hit with width = 0, rsp_phys = base + offset.
- R6: On a miss, rsp_hit is 0 and rsp_phys is 0.
- R7: rsp_valid rises exactly 16 clock edges after the edge that accepts a request. This holds for every kind of result.
- R8: req_ready is high only when no request is in flight. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_hit and rsp_phys hold steady. The cycle after a taken response, req_ready is 1.
- R9: The descriptor is sampled at acceptance. A commit during an in-flight translation affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shadow byte write enable |
| cfg_sel | input | 4 | Shadow byte select code |
| cfg_wdata | input | 8 | Shadow byte value |
| cfg_commit | input | 1 | Copy shadow descriptor to active |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Host address to translate |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Address lies inside the window |
| rsp_phys | output | 32 | Translated physical address |

## Verification
The hardest situation to reach is a commit that lands while a translation is halfway through its divide. Reaching it needs a request accepted first and then a burst of register writes and a commit squeezed into the next 16 cycles. The bench does this by returning from its request task right after acceptance and issuing the byte writes immediately. The expected value was queued at send time, so it reflects the old descriptor. Back-pressure on the response is reached by holding rsp_ready low across a response. Window edges are covered by addresses on both sides of the limits, including a window that reaches page 0xFF.

// File: rtl/stride_xlat_pkg.sv
package stride_xlat_pkg;
    localparam int BYTE_W = 8;
    localparam int PAGE_SHIFT = 8;

    typedef enum logic [1:0] {
        SX_IDLE,
        SX_DIVIDE,
        SX_DONE
    } sx_state_e;
endpackage

// File: rtl/stride_xlat_regs.sv
// Shadow and active descriptor registers; byte writes land in shadow,
// a commit copies the whole shadow set into the active set at once.
module stride_xlat_regs
    import stride_xlat_pkg::*;
#(
    parameter int PHYS_AW  = 32,
    parameter int PG_W     = 8,
    parameter int STRIDE_W = 8,
    parameter int WIDTH_W  = 16,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [BYTE_W-1:0]   cfg_wdata,
    input  logic                cfg_commit,
    output logic [PHYS_AW-1:0]  act_base,
    output logic [PG_W-1:0]     act_start,
    output logic [PG_W-1:0]     act_size,
    output logic [STRIDE_W-1:0] act_stride,
    output logic [WIDTH_W-1:0]  act_width
);
    localparam int NB_BASE    = PHYS_AW / BYTE_W;
    localparam int NB_WID     = WIDTH_W / BYTE_W;
    localparam int SEL_START  = NB_BASE;
    localparam int SEL_SIZE   = NB_BASE + 1;
    localparam int SEL_STRIDE = NB_BASE + 2;
    localparam int SEL_WID0   = NB_BASE + 3;

    logic [PHYS_AW-1:0]  sh_base;
    logic [PG_W-1:0]     sh_start;
    logic [PG_W-1:0]     sh_size;
    logic [STRIDE_W-1:0] sh_stride;
    logic [WIDTH_W-1:0]  sh_width;

    // R2: shadow byte writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_base   <= '0;
            sh_start  <= '0;
            sh_size   <= '0;
            sh_stride <= '0;
            sh_width  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NB_BASE; i++) begin
                if (cfg_sel == SEL_W'(i)) sh_base[BYTE_W*i +: BYTE_W] <= cfg_wdata;
            end
            if (cfg_sel == SEL_W'(SEL_START))  sh_start  <= cfg_wdata[PG_W-1:0];
            if (cfg_sel == SEL_W'(SEL_SIZE))   sh_size   <= cfg_wdata[PG_W-1:0];
            if (cfg_sel == SEL_W'(SEL_STRIDE)) sh_stride <= cfg_wdata[STRIDE_W-1:0];
            for (int j = 0; j < NB_WID; j++) begin
                if (cfg_sel == SEL_W'(SEL_WID0 + j)) sh_width[BYTE_W*j +: BYTE_W] <= cfg_wdata;
            end
        end
    end

    // R2: commit makes the shadow set active in one edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_base   <= '0;
            act_start  <= '0;
            act_size   <= '0;
            act_stride <= '0;
            act_width  <= '0;
        end else if (cfg_commit) begin
            act_base   <= sh_base;
            act_start  <= sh_start;
            act_size   <= sh_size;
            act_stride <= sh_stride;
            act_width  <= sh_width;
        end
    end
endmodule

// File: rtl/stride_xlat_window.sv
// Page window test and window-relative offset.
module stride_xlat_window
    import stride_xlat_pkg::*;
#(
    parameter int HOST_AW = 16,
    parameter int PG_W    = HOST_AW - PAGE_SHIFT
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic [PG_W-1:0]    start_pg,
    input  logic [PG_W-1:0]    size_pg,
    output logic               hit,
    output logic [HOST_AW-1:0] offset
);
    logic [PG_W-1:0] page;
    logic [PG_W:0]   limit;

    always_comb begin
        page   = addr[HOST_AW-1 -: PG_W];
        // R3: nine-bit limit, no wrap past the top page
        limit  = {1'b0, start_pg} + {1'b0, size_pg};
        hit    = ({1'b0, page} >= {1'b0, start_pg}) && ({1'b0, page} < limit);
        offset = addr - {start_pg, {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/stride_xlat_div.sv
// Restoring divider, one quotient bit per step.
module stride_xlat_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] quo_q, rem_q, dvs_q;
    logic [W:0]   trial, diff;
    logic         ge;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dvs_q};
        ge    = trial >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            dvs_q <= divisor;
        end else if (step) begin
            rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], ge};
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;
endmodule

// File: rtl/stride_xlat.sv
// Strided aperture translator top: descriptor registers, window test,
// serial divider and the request/response controller.
module stride_xlat
    import stride_xlat_pkg::*;
#(
    parameter int HOST_AW   = 16,
    parameter int PHYS_AW   = 32,
    parameter int STRIDE_W  = 8,
    parameter int WIDTH_W   = 16,
    parameter int CFG_SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    input  logic                 cfg_commit,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [HOST_AW-1:0]   req_addr,
    input  logic                 rsp_ready,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [PHYS_AW-1:0]   rsp_phys
);
    localparam int PG_W  = HOST_AW - PAGE_SHIFT;
    localparam int DIV_W = (HOST_AW > WIDTH_W) ? HOST_AW : WIDTH_W;
    localparam int CNT_W = $clog2(DIV_W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_W - 1);

    logic [PHYS_AW-1:0]  act_base;
    logic [PG_W-1:0]     act_start, act_size;
    logic [STRIDE_W-1:0] act_stride;
    logic [WIDTH_W-1:0]  act_width;

    logic               win_hit;
    logic [HOST_AW-1:0] win_off;

    sx_state_e           state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic                hit_q, lin_q;
    logic [PHYS_AW-1:0]  base_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [HOST_AW-1:0]  off_q;
    logic                accept, div_step;
    logic [DIV_W-1:0]    quo, rem;
    logic [PHYS_AW-1:0]  phys_calc;

    stride_xlat_regs #(
        .PHYS_AW(PHYS_AW), .PG_W(PG_W), .STRIDE_W(STRIDE_W),
        .WIDTH_W(WIDTH_W), .SEL_W(CFG_SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .act_base(act_base), .act_start(act_start), .act_size(act_size),
        .act_stride(act_stride), .act_width(act_width)
    );

    stride_xlat_window #(.HOST_AW(HOST_AW), .PG_W(PG_W)) u_win (
        .addr(req_addr), .start_pg(act_start), .size_pg(act_size),
        .hit(win_hit), .offset(win_off)
    );

    stride_xlat_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .step(div_step),
        .dividend(DIV_W'(win_off)), .divisor(DIV_W'(act_width)),
        .quo(quo), .rem(rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SX_IDLE:   if (req_valid)      state_d = SX_DIVIDE;
            SX_DIVIDE: if (cnt_q == LAST)  state_d = SX_DONE;
            SX_DONE:   if (rsp_ready)      state_d = SX_IDLE;
            default:                       state_d = SX_IDLE;
        endcase
    end

    // R9: descriptor snapshot at acceptance; step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            hit_q    <= 1'b0;
            lin_q    <= 1'b0;
            base_q   <= '0;
            stride_q <= '0;
            off_q    <= '0;
        end else if (accept) begin
            cnt_q    <= '0;
            hit_q    <= win_hit;
            lin_q    <= (act_width == '0);
            base_q   <= act_base;
            stride_q <= act_stride;
            off_q    <= win_off;
        end else if (state_q == SX_DIVIDE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4 / R5: address arithmetic from quotient and remainder
    always_comb begin
        if (lin_q)
            phys_calc = base_q + PHYS_AW'(off_q);
        else
            phys_calc = base_q
                      + ((PHYS_AW'(quo) * PHYS_AW'(stride_q)) << PAGE_SHIFT)
                      + PHYS_AW'(rem);
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == SX_IDLE);
        accept    = req_valid && (state_q == SX_IDLE);
        div_step  = (state_q == SX_DIVIDE);
        rsp_valid = (state_q == SX_DONE);
        rsp_hit   = (state_q == SX_DONE) && hit_q;
        rsp_phys  = ((state_q == SX_DONE) && hit_q) ? phys_calc : '0;
    end
endmodule

// File: rtl/stride_xlat_chk.sv
module stride_xlat_chk #(
    parameter int PHYS_AW = 32,
    parameter int LAT     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_hit,
    input logic [PHYS_AW-1:0] rsp_phys
);
    logic        busy;
    logic [15:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cyc  <= '0;
        end else if (req_valid && req_ready) begin
            busy <= 1'b1;
            cyc  <= '0;
        end else begin
            if (busy && !rsp_valid) cyc <= cyc + 16'd1;
            if (rsp_valid && rsp_ready) busy <= 1'b0;
        end
    end

    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (busy && cyc == 16'(LAT)));

    a_r8_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) && $stable(rsp_hit)));

    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

    a_r8_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_phys == '0));
endmodule

bind stride_xlat stride_xlat_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_phys(rsp_phys)
);

// File: tb/sim_stride_xlat.sv
module sim_stride_xlat;
    localparam int PERIOD = 10;
    localparam int LAT    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_commit = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        rsp_ready = 1'b1;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_phys;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stride_xlat u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_phys(rsp_phys)
    );

    // Bench model of shadow and active descriptor
    logic [31:0] s_base = 0, a_base = 0;
    logic [7:0]  s_start = 0, a_start = 0, s_size = 0, a_size = 0, s_stride = 0, a_stride = 0;
    logic [15:0] s_width = 0, a_width = 0;

    typedef struct {
        logic        hit;
        logic [31:0] phys;
        int          acc;
        string       tag;
    } item_t;
    item_t q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic item_t model(input logic [15:0] a, input string tag);
        item_t it;
        logic [8:0]  lim;
        logic [15:0] off, row, col;
        lim = {1'b0, a_start} + {1'b0, a_size};
        it.tag = tag;
        it.acc = 0;
        it.hit = (a_size != 0) && (a[15:8] >= a_start) && ({1'b0, a[15:8]} < lim);
        off = a - {a_start, 8'h00};
        if (!it.hit) it.phys = 32'h0;
        else if (a_width == 0) it.phys = a_base + {16'h0, off};
        else begin
            row = off / a_width;
            col = off % a_width;
            it.phys = a_base + (({16'h0, row} * {24'h0, a_stride}) << 8) + {16'h0, col};
        end
        return it;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            4'd0: s_base[7:0]   = d;
            4'd1: s_base[15:8]  = d;
            4'd2: s_base[23:16] = d;
            4'd3: s_base[31:24] = d;
            4'd4: s_start = d;
            4'd5: s_size = d;
            4'd6: s_stride = d;
            4'd7: s_width[7:0] = d;
            4'd8: s_width[15:8] = d;
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        a_base = s_base; a_start = s_start; a_size = s_size;
        a_stride = s_stride; a_width = s_width;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic set_desc(input logic [31:0] b, input logic [7:0] st, input logic [7:0] sz,
                            input logic [7:0] strd, input logic [15:0] w);
        for (int i = 0; i < 4; i++) wr(4'(i), b[8*i +: 8]);
        wr(4'd4, st); wr(4'd5, sz); wr(4'd6, strd);
        wr(4'd7, w[7:0]); wr(4'd8, w[15:8]);
        commit();
    endtask

    // Driver: queue expectation, present request, return after acceptance
    task automatic send(input logic [15:0] a, input string tag);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        it = model(a, tag);
        it.acc = cyc;
        q.push_back(it);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: samples late in each cycle, before the next rising edge
    logic prev_v = 1'b0;
    always begin
        @(negedge clk);
        #(PERIOD/4);
        if (rst_n) begin
            if (rsp_valid && !prev_v) begin
                if (q.size() == 0) chk(1'b0, "R8 unexpected response", 64'(rsp_phys), 64'h0);
                // R7: accept edge E, response visible from edge E+LAT; sample lands one count later
                else chk((cyc - q[0].acc) == LAT + 1, "R7 latency", 64'(cyc - q[0].acc), 64'(LAT + 1));
            end
            if (rsp_valid && rsp_ready && q.size() != 0) begin
                item_t it;
                it = q.pop_front();
                chk({rsp_hit, rsp_phys} == {it.hit, it.phys}, it.tag,
                    {31'h0, rsp_hit, rsp_phys}, {31'h0, it.hit, it.phys});
            end
            prev_v = rsp_valid;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        item_t hold;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1 req_ready", 64'(req_ready), 64'h1);
        chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'h0);
        send(16'h0000, "R1 zero descriptor miss");
        drain();

        // R2: shadow writes without commit do not take effect
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h10); wr(4'd3, 8'h00);
        wr(4'd4, 8'h40); wr(4'd5, 8'h08); wr(4'd6, 8'h04);
        wr(4'd7, 8'd40); wr(4'd8, 8'h00);
        wr(4'd12, 8'hFF); // R2: unused select code ignored
        send(16'h4000, "R2 before commit");
        drain();
        commit();

        // R4: strided map, base 0x100000 width 40 stride 4
        send(16'h4000, "R4 row0 col0");
        send(16'h4027, "R4 row0 last col");
        send(16'h4028, "R4 row1 col0");
        send(16'h4051, "R4 row2 col1");
        // R3: window edges; R6 miss output
        send(16'h47FF, "R3 last byte in window");
        send(16'h4800, "R3 R6 first byte past window");
        send(16'h3FFF, "R3 R6 byte below window");
        drain();

        // R4: base +1 shifts a byte, base +stride*256 shifts a line
        set_desc(32'h0010_0001, 8'h40, 8'h08, 8'h04, 16'd40);
        send(16'h4028, "R4 base plus one");
        set_desc(32'h0010_0400, 8'h40, 8'h08, 8'h04, 16'd40);
        send(16'h4000, "R4 base plus one line");
        drain();

        // R5: width zero gives a linear map
        set_desc(32'h0200_0000, 8'h40, 8'h04, 8'h04, 16'd0);
        send(16'h4123, "R5 linear");
        // R4: width 1 makes every byte its own row
        set_desc(32'h0200_0000, 8'h40, 8'h04, 8'h02, 16'd1);
        send(16'h4003, "R4 width one");
        // R4: width wider than window keeps row 0
        set_desc(32'h0200_0000, 8'h40, 8'h04, 8'h02, 16'hFFFF);
        send(16'h43FE, "R4 wide line");
        drain();

        // R3: window touching the top page does not wrap to page 0
        set_desc(32'hFFFF_FF00, 8'hF8, 8'h10, 8'h03, 16'd100);
        send(16'hFF00, "R3 R4 top page hit with phys wrap");
        send(16'h0000, "R3 no wrap to page 0");
        send(16'hF7FF, "R3 below start");
        // R3: size zero never hits
        set_desc(32'h0000_1000, 8'h20, 8'h00, 8'h01, 16'd8);
        send(16'h2000, "R3 size zero");
        drain();

        // R8: response held under back-pressure
        set_desc(32'h0003_0000, 8'h80, 8'h10, 8'h05, 16'd33);
        @(negedge clk);
        rsp_ready = 1'b0;
        hold = model(16'h8123, "R8 held");
        send(16'h8123, "R8 held response");
        repeat (25) @(negedge clk);
        chk(rsp_valid === 1'b1, "R8 valid held", 64'(rsp_valid), 64'h1);
        chk(req_ready === 1'b0, "R8 not ready while held", 64'(req_ready), 64'h0);
        chk(rsp_phys === hold.phys, "R8 phys held", 64'(rsp_phys), 64'(hold.phys));
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R8 ready after take", 64'(req_ready), 64'h1);
        drain();

        // R9: commit while a translation is in flight
        send(16'h8456, "R9 in flight uses old descriptor");
        wr(4'd2, 8'h07);
        wr(4'd6, 8'h09);
        commit();
        drain();
        send(16'h8456, "R9 next request uses new descriptor");
        drain();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule